// File: doc/BRIEF.md
# DMA Peripheral Request Selector

This block is the per-channel front end of a DMA controller. It watches seven peripheral request lines. Four come from two serial ports: a transmit-empty and a receive-full line for each port. Three are timer input-capture lines. A 4-bit select code picks one of the seven lines.

Each request line passes through a synchroniser and an edge detector. A rising edge on the selected line produces one single-cycle start pulse, but only when all five enable terms allow it. The block also checks that the programmed source and destination address classes suit the selected request. It grants a bus mode: cycle steal only for serial requests, and burst or cycle steal for timer requests.

A serial request with a bad route, or with a burst request, sets a sticky configuration-error flag. That flag blocks all further starts until reset. After a cycle-steal start, the channel must return a transfer-done acknowledge before another start can fire.

Top module: `dma_preq_select`

## Requirements
- R1: Select codes 1000 to 1110 (binary) choose request line index equal to code minus 8. The lines are: 0 port A transmit-empty, 1 port A receive-full, 2 port B transmit-empty, 3 port B receive-full, 4 to 6 timer capture. Edges on any other line never cause a start.
- R2: Any select code outside 1000 to 1110 never produces a start, and the granted bus mode stays 0 for it.
- R3: A start needs all five enable terms to hold on the cycle the request edge is seen: channel enable = 1, master enable = 1, transfer-end flag = 0, NMI flag = 0 and address-error flag = 0.
- R4: A rising edge on the selected line gives exactly one start pulse, one cycle wide. The pulse is high in the cycle after the third rising clock edge that follows the request rising. Holding the request high gives no further pulse.
- R5: For receive codes (1001, 1011), the source tag must be that port's receive register and the destination tag must be external. Tags are 3 bits: 0 external, 1 on-chip peripheral, 2 port A receive, 3 port A transmit, 4 port B receive, 5 port B transmit.
- R6: For transmit codes (1000, 1010), the destination tag must be that port's transmit register (3 for A, 5 for B), and the source tag must be external (0).
- R7: For serial codes the granted bus mode is always cycle steal (output 0). A burst request made with a serial code is a configuration error.
- R8: For timer codes the granted bus mode (1 = burst) follows the burst request, one clock later. Source and destination tags are not checked for timer codes.
- R9: A selected request edge that arrives with a configuration error sets the configuration-error flag in the same cycle the start would have appeared, and suppresses that start. The flag stays set, and blocks every later start, until reset.
- R10: After a start granted in cycle-steal mode, no further start fires until done_ack has been sampled high. Starts granted in burst mode leave no such block.
- R11: After reset, start, cfg_err and burst_mode are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | NUM_REQ | Asynchronous peripheral request lines |
| sel_code | input | 4 | Request select code |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Master DMA enable |
| xfer_end | input | 1 | Transfer-end flag |
| nmi_flag | input | 1 | NMI flag |
| addr_err | input | 1 | Address-error flag |
| src_tag | input | 3 | Address class of the transfer source |
| dst_tag | input | 3 | Address class of the transfer destination |
| burst_req | input | 1 | Requested bus mode, 1 = burst |
| done_ack | input | 1 | Transfer-done acknowledge from the channel |
| start | output | 1 | Single-cycle transfer start pulse |
| cfg_err | output | 1 | Sticky configuration-error flag |
| burst_mode | output | 1 | Granted bus mode, 1 = burst |

## Verification
The start pulse and the error flag are both due after the third rising clock edge that follows a request rising: two edges through the synchroniser and one into the output register. The granted bus mode is due one edge after the select code or burst request changes. The busy block clears on the edge that samples done_ack. Every check drives inputs on a falling edge and counts falling edges to the cycle the result is due. At that point it checks both the due value and the cycles on either side, so a pulse that comes early, comes late or stretches is seen.

// File: rtl/dmapr_pkg.sv
package dmapr_pkg;

  localparam int SEL_W = 4;
  localparam int TAG_W = 3;
  localparam int IDX_W = SEL_W - 1;

  typedef enum logic [TAG_W-1:0] {
    TAG_EXT    = 3'd0,
    TAG_ONCHIP = 3'd1,
    TAG_A_RXD  = 3'd2,
    TAG_A_TXD  = 3'd3,
    TAG_B_RXD  = 3'd4,
    TAG_B_TXD  = 3'd5
  } tag_e;

  typedef struct packed {
    logic             hit;
    logic             serial;
    logic             rx;
    logic             port_b;
    logic [IDX_W-1:0] idx;
  } sel_info_t;

  // Top bit marks a peripheral request; bit 2 separates timer from serial;
  // for serial codes bit 1 picks the port and bit 0 picks receive.
  function automatic sel_info_t decode_sel(input logic [SEL_W-1:0] code);
    sel_info_t r;
    r.hit    = code[SEL_W-1];
    r.serial = ~code[2];
    r.port_b = code[1];
    r.rx     = code[0];
    r.idx    = code[IDX_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/dmapr_sync_edge.sv
module dmapr_sync_edge #(
  parameter int NUM_REQ     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_REQ-1:0] rise
);

  // Stages 0..SYNC_STAGES-1 synchronise; the last stage holds the previous value.
  logic [NUM_REQ-1:0] stg [0:SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= SYNC_STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= req_in;
      for (int s = 1; s <= SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_edge
    assign rise[i] = stg[SYNC_STAGES-1][i] & ~stg[SYNC_STAGES][i];
  end

endmodule

// File: rtl/dmapr_route_check.sv
module dmapr_route_check
  import dmapr_pkg::*;
#(
  parameter int NUM_REQ = 7
) (
  input  logic [SEL_W-1:0] sel_code,
  input  logic [TAG_W-1:0] src_tag,
  input  logic [TAG_W-1:0] dst_tag,
  input  logic             burst_req,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  output logic             cfg_bad,
  output logic             grant_burst
);

  sel_info_t        info;
  logic             serial_sel;
  logic [TAG_W-1:0] need_src;
  logic [TAG_W-1:0] need_dst;
  logic             route_bad;

  always_comb begin
    info       = decode_sel(sel_code);
    sel_valid  = info.hit && (int'(info.idx) < NUM_REQ);
    sel_idx    = info.idx;
    serial_sel = sel_valid && info.serial;

    if (info.rx) begin
      need_src = info.port_b ? TAG_B_RXD : TAG_A_RXD;
      need_dst = TAG_EXT;
    end else begin
      need_src = TAG_EXT;
      need_dst = info.port_b ? TAG_B_TXD : TAG_A_TXD;
    end

    route_bad   = (src_tag != need_src) || (dst_tag != need_dst);
    cfg_bad     = serial_sel && (route_bad || burst_req);
    grant_burst = sel_valid && !info.serial && burst_req;
  end

endmodule

// File: rtl/dmapr_start_ctrl.sv
module dmapr_start_ctrl
  import dmapr_pkg::*;
#(
  parameter int NUM_REQ = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] rise,
  input  logic               sel_valid,
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic               cfg_bad,
  input  logic               grant_burst,
  input  logic               en_ok,
  input  logic               done_ack,
  output logic               start,
  output logic               cfg_err,
  output logic               burst_mode
);

  localparam int PAD_W = 1 << IDX_W;

  logic [PAD_W-1:0] rise_pad;
  logic             sel_rise;
  logic             fire_ok;
  logic             busy_q;
  logic             err_q;
  logic             start_q;
  logic             burst_q;

  assign rise_pad = PAD_W'(rise);
  assign sel_rise = sel_valid && rise_pad[sel_idx];
  assign fire_ok  = sel_rise && en_ok && !cfg_bad && !err_q && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      burst_q <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= fire_ok;
      burst_q <= grant_burst;
      err_q   <= err_q | (sel_rise & cfg_bad);
      if (fire_ok && !grant_burst) busy_q <= 1'b1;
      else if (done_ack)           busy_q <= 1'b0;
    end
  end

  assign start      = start_q;
  assign cfg_err    = err_q;
  assign burst_mode = burst_q;

endmodule

// File: rtl/dma_preq_select.sv
module dma_preq_select
  import dmapr_pkg::*;
#(
  parameter int NUM_REQ     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic [SEL_W-1:0]   sel_code,
  input  logic               chan_en,
  input  logic               master_en,
  input  logic               xfer_end,
  input  logic               nmi_flag,
  input  logic               addr_err,
  input  logic [TAG_W-1:0]   src_tag,
  input  logic [TAG_W-1:0]   dst_tag,
  input  logic               burst_req,
  input  logic               done_ack,
  output logic               start,
  output logic               cfg_err,
  output logic               burst_mode
);

  logic [NUM_REQ-1:0] rise;
  logic               sel_valid;
  logic [IDX_W-1:0]   sel_idx;
  logic               cfg_bad;
  logic               grant_burst;
  logic               en_ok;

  assign en_ok = chan_en & master_en & ~xfer_end & ~nmi_flag & ~addr_err;

  dmapr_sync_edge #(
    .NUM_REQ     (NUM_REQ),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_in),
    .rise   (rise)
  );

  dmapr_route_check #(
    .NUM_REQ (NUM_REQ)
  ) u_route (
    .sel_code    (sel_code),
    .src_tag     (src_tag),
    .dst_tag     (dst_tag),
    .burst_req   (burst_req),
    .sel_valid   (sel_valid),
    .sel_idx     (sel_idx),
    .cfg_bad     (cfg_bad),
    .grant_burst (grant_burst)
  );

  dmapr_start_ctrl #(
    .NUM_REQ (NUM_REQ)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .sel_valid   (sel_valid),
    .sel_idx     (sel_idx),
    .cfg_bad     (cfg_bad),
    .grant_burst (grant_burst),
    .en_ok       (en_ok),
    .done_ack    (done_ack),
    .start       (start),
    .cfg_err     (cfg_err),
    .burst_mode  (burst_mode)
  );

endmodule

// File: rtl/dmapr_checker.sv
module dmapr_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sel_code,
  input logic       chan_en,
  input logic       master_en,
  input logic       xfer_end,
  input logic       nmi_flag,
  input logic       addr_err,
  input logic [2:0] src_tag,
  input logic [2:0] dst_tag,
  input logic       burst_req,
  input logic       done_ack,
  input logic       start,
  input logic       cfg_err,
  input logic       burst_mode
);

  // Outstanding cycle-steal transfer, rebuilt from the outputs alone.
  logic pend_now;
  logic pend_q;

  assign pend_now = (start && !burst_mode) || pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_now && !done_ack;
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R2
  start_code_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> ($past(sel_code) >= 4'b1000 && $past(sel_code) <= 4'b1110));

  // R3
  start_enable_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(chan_en && master_en && !xfer_end && !nmi_flag && !addr_err));

  // R5
  rx_route_chk: assert property (@(posedge clk) disable iff (rst)
    (start && $past(sel_code[3:2] == 2'b10 && sel_code[0]))
      |-> $past(dst_tag == 3'd0 && src_tag == (sel_code[1] ? 3'd4 : 3'd2)));

  // R6
  tx_route_chk: assert property (@(posedge clk) disable iff (rst)
    (start && $past(sel_code[3:2] == 2'b10 && !sel_code[0]))
      |-> $past(src_tag == 3'd0 && dst_tag == (sel_code[1] ? 3'd5 : 3'd3)));

  // R7
  burst_source_chk: assert property (@(posedge clk) disable iff (rst)
    burst_mode |-> $past(sel_code[3:2] == 2'b11 && sel_code != 4'b1111 && burst_req));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R9
  err_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !start);

  // R10
  steal_block_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(pend_now));

endmodule

bind dma_preq_select dmapr_checker u_dmapr_checker (
  .clk        (clk),
  .rst        (rst),
  .sel_code   (sel_code),
  .chan_en    (chan_en),
  .master_en  (master_en),
  .xfer_end   (xfer_end),
  .nmi_flag   (nmi_flag),
  .addr_err   (addr_err),
  .src_tag    (src_tag),
  .dst_tag    (dst_tag),
  .burst_req  (burst_req),
  .done_ack   (done_ack),
  .start      (start),
  .cfg_err    (cfg_err),
  .burst_mode (burst_mode)
);

// File: tb/test_dma_preq_select.sv
module test_dma_preq_select;
  import dmapr_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_in = '0;
  logic [3:0] sel_code = '0;
  logic       chan_en = 1'b1;
  logic       master_en = 1'b1;
  logic       xfer_end = 1'b0;
  logic       nmi_flag = 1'b0;
  logic       addr_err = 1'b0;
  logic [2:0] src_tag = '0;
  logic [2:0] dst_tag = '0;
  logic       burst_req = 1'b0;
  logic       done_ack = 1'b0;
  logic       start;
  logic       cfg_err;
  logic       burst_mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_preq_select i_dma_preq_select (
    .clk(clk), .rst(rst), .req_in(req_in), .sel_code(sel_code),
    .chan_en(chan_en), .master_en(master_en), .xfer_end(xfer_end),
    .nmi_flag(nmi_flag), .addr_err(addr_err), .src_tag(src_tag),
    .dst_tag(dst_tag), .burst_req(burst_req), .done_ack(done_ack),
    .start(start), .cfg_err(cfg_err), .burst_mode(burst_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_in = '0; done_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] code, input logic [2:0] s,
                       input logic [2:0] d, input logic b);
    @(negedge clk);
    sel_code = code; src_tag = s; dst_tag = d; burst_req = b;
  endtask

  task automatic ack();
    @(negedge clk) done_ack = 1'b1;
    @(negedge clk) done_ack = 1'b0;
  endtask

  // Raise one line; the pulse is due after the third rising edge.
  task automatic fire(input int line, input bit exp_start, input bit exp_bm,
                      input string req);
    @(negedge clk) req_in[line] = 1'b1;
    repeat (2) @(negedge clk);
    check(req, "start before due", start, 0);
    @(negedge clk);
    check(req, "start when due", start, exp_start);
    if (exp_start) check(req, "granted mode", burst_mode, exp_bm);
    @(negedge clk);
    check("R4", "pulse width", start, 0);
    repeat (3) @(negedge clk);
    check("R4", "held request", start, 0);
    req_in[line] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11", "start after reset", start, 0);
    check("R11", "cfg_err after reset", cfg_err, 0);
    check("R11", "burst_mode after reset", burst_mode, 0);
  endtask

  task automatic t_serial_routes();
    setup(4'b1001, TAG_A_RXD, TAG_EXT, 1'b0); fire(1, 1, 0, "R5"); ack();
    setup(4'b1011, TAG_B_RXD, TAG_EXT, 1'b0); fire(3, 1, 0, "R5"); ack();
    setup(4'b1000, TAG_EXT, TAG_A_TXD, 1'b0); fire(0, 1, 0, "R6"); ack();
    setup(4'b1010, TAG_EXT, TAG_B_TXD, 1'b0); fire(2, 1, 0, "R6"); ack();
    check("R9", "no error on good routes", cfg_err, 0);
  endtask

  task automatic t_wrong_line();
    setup(4'b1011, TAG_B_RXD, TAG_EXT, 1'b0);
    fire(1, 0, 0, "R1");
    fire(4, 0, 0, "R1");
    fire(3, 1, 0, "R1");
    ack();
  endtask

  task automatic t_enables();
    setup(4'b1001, TAG_A_RXD, TAG_EXT, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chan_en = (k != 0); master_en = (k != 1);
      xfer_end = (k == 2); nmi_flag = (k == 3); addr_err = (k == 4);
      fire(1, 0, 0, "R3");
    end
    @(negedge clk);
    chan_en = 1'b1; master_en = 1'b1;
    xfer_end = 1'b0; nmi_flag = 1'b0; addr_err = 1'b0;
    fire(1, 1, 0, "R3");
    ack();
  endtask

  task automatic t_steal_block();
    setup(4'b1100, TAG_EXT, TAG_EXT, 1'b0);
    fire(4, 1, 0, "R10");
    fire(4, 0, 0, "R10");
    ack();
    fire(4, 1, 0, "R10");
    ack();
  endtask

  task automatic t_timer_burst();
    setup(4'b1100, TAG_EXT, TAG_EXT, 1'b1);
    @(negedge clk);
    check("R8", "burst granted one edge later", burst_mode, 1);
    fire(4, 1, 1, "R8");
    fire(4, 1, 1, "R10");
    setup(4'b1101, TAG_A_RXD, TAG_B_TXD, 1'b1);
    fire(5, 1, 1, "R8");
    setup(4'b1110, TAG_ONCHIP, TAG_EXT, 1'b0);
    fire(6, 1, 0, "R8");
    ack();
    check("R8", "timer tags unchecked", cfg_err, 0);
  endtask

  task automatic t_invalid();
    logic [3:0] codes [4] = '{4'b0000, 4'b0101, 4'b0111, 4'b1111};
    for (int c = 0; c < 4; c++) begin
      setup(codes[c], TAG_EXT, TAG_EXT, 1'b1);
      @(negedge clk);
      check("R2", "burst_mode for unlisted code", burst_mode, 0);
      for (int l = 0; l < 7; l++) fire(l, 0, 0, "R2");
    end
    check("R2", "no error for unlisted code", cfg_err, 0);
  endtask

  task automatic t_cfg_err();
    do_reset();
    setup(4'b1001, TAG_A_RXD, TAG_ONCHIP, 1'b0); fire(1, 0, 0, "R5");
    check("R5", "bad receive destination", cfg_err, 1);
    do_reset();
    setup(4'b1011, TAG_A_RXD, TAG_EXT, 1'b0); fire(3, 0, 0, "R5");
    check("R5", "wrong port receive register", cfg_err, 1);
    do_reset();
    setup(4'b1010, TAG_ONCHIP, TAG_B_TXD, 1'b0); fire(2, 0, 0, "R6");
    check("R6", "bad transmit source", cfg_err, 1);
    do_reset();
    setup(4'b1000, TAG_EXT, TAG_A_TXD, 1'b1);
    @(negedge clk);
    check("R7", "serial never granted burst", burst_mode, 0);
    check("R9", "flag waits for request edge", cfg_err, 0);
    fire(0, 0, 0, "R7");
    check("R7", "burst with serial code", cfg_err, 1);
    setup(4'b1000, TAG_EXT, TAG_A_TXD, 1'b0); fire(0, 0, 0, "R9");
    setup(4'b1100, TAG_EXT, TAG_EXT, 1'b1);   fire(4, 0, 0, "R9");
    check("R9", "flag sticky", cfg_err, 1);
    do_reset();
    check("R9", "flag cleared by reset", cfg_err, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_serial_routes();
    t_wrong_line();
    t_enables();
    t_steal_block();
    t_timer_burst();
    t_invalid();
    t_cfg_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule